// File: doc/BRIEF.md
# Latency-Matrix Issue Interlock

This unit sits at the issue stage of a single-issue, in-order pipeline that keeps separate integer and floating-point register files. Each cycle the issue stage presents at most one instruction, described by an operation class and three register tags. The unit compares the instruction's source tags against producers still in flight. It holds `stall_o` high until the spacing that the producer class and the consumer's use of the value require has passed. An instruction issues in a cycle where `ins_valid` is high and `stall_o` is low. While stalled, the issue stage holds the instruction steady.

For each register, a down-counter is loaded when a producer issues, together with a flag that records whether that producer was a load. The counter then steps down by one every clock, stalled or not. The required wait comes from a fixed producer/consumer latency matrix, not from one generic load-use rule. A consumer that issues k cycles after its producer is held for max(0, L-(k-1)) cycles. Registers are matched by tag only, and integer and FP tags are separate namespaces.

A two-state machine tracks the single delayed-branch slot. It has two states. In RUN, no slot is pending. SLOT means a branch has issued and the next instruction to issue occupies its delay slot. The transition RUN to SLOT takes place when a branch issues. The transition SLOT to RUN takes place when any instruction issues. `in_slot_o` is high in SLOT. A cumulative count of stall cycles is provided so that the cost of a code sequence can be measured.

Top module: `ilk_interlock`

## Requirements
- R1: After reset, `stall_o` is 0, `in_slot_o` is 0 and `stall_total_o` is 0.
- R2: An FP ALU producer (op code 2; reads FP tags `src_a_i`/`src_b_i` and writes FP tag `dst_i`) followed at once by an FP ALU consumer of its result stalls that consumer for 3 cycles.
- R3: An FP ALU result used as the data of a store double (op code 4; `src_a_i` is the integer base, `src_b_i` is the FP data) immediately after its producer stalls the store for 2 cycles.
- R4: A load double result (op code 3; integer base in `src_a_i`, FP destination in `dst_i`) used by an FP ALU op immediately after the load stalls the consumer for 1 cycle.
- R5: A load double result used as store-double data immediately after the load causes no stall.
- R6: Integer results (op code 1; integer tags `src_a_i`, `src_b_i`, `dst_i`) never stall integer ops, store base registers or a branch source (op code 5; integer tag `src_a_i`).
- R7: A consumer issued k cycles after its producer stalls for max(0, L-(k-1)) cycles, where L is the matrix latency; independent instructions placed between them reduce the stall.
- R8: An integer write never causes a stall for an FP read of the same index, and an FP write never causes a stall for an integer read of the same index.
- R9: After a branch (op code 5) issues, `in_slot_o` is 1 while exactly one following instruction is presented, up to and including the cycle it issues; it then returns to 0. Op code 0 is a no-op that fills a slot.
- R10: `stall_total_o` grows by one for each cycle with `stall_o` high and holds otherwise.
- R11: Only read-after-write dependences stall. Writing a register that has a pending write (WAW), writing a register an earlier op read (WAR), and cycles with `ins_valid` low give no stall.
- R12: The loop load / FP add / store / integer decrement / branch / no-op costs 9 cycles per iteration. Reordered as load / FP add / decrement / branch / store-in-slot, it costs 6 cycles per iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | An instruction is presented for issue |
| ins_op | input | 3 | Class: 0 no-op, 1 integer, 2 FP ALU, 3 load double, 4 store double, 5 branch |
| dst_i | input | TAGW (5) | Destination register tag |
| src_a_i | input | TAGW (5) | First source tag |
| src_b_i | input | TAGW (5) | Second source tag |
| stall_o | output | 1 | Hold the presented instruction this cycle |
| in_slot_o | output | 1 | The presented instruction occupies a branch delay slot |
| stall_total_o | output | CNT_W (16) | Cumulative stall cycles since reset |

## Verification
Back-to-back producer/consumer pairs cover every cell of the latency matrix, so a swapped or off-by-one latency shows up as a wrong stall length for one specific class pair. Sequences with one, two and three independent instructions between producer and consumer separate a counter that steps down every cycle from one that freezes or resets. Same-index reads across the two register files, together with WAW and WAR pairs, show whether any stall is raised without a true dependence. The two versions of the vector loop, plus a long run of random instructions on a four-tag pool with dense dependences, tie the per-cycle stall, the slot flag and the counter to a model of issue times in the bench.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_INT  = 3'd1,
        OP_FALU = 3'd2,
        OP_LDD  = 3'd3,
        OP_STD  = 3'd4,
        OP_BR   = 3'd5
    } op_e;

    typedef enum logic {
        SL_RUN  = 1'b0,
        SL_SLOT = 1'b1
    } slot_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Remaining wait for one consumer use: the counter was loaded with the
    // producer's largest latency, so this use is clear once it reaches max-need.
    function automatic logic must_wait(input int cnt, input logic by_load,
                                       input int need_ld, input int need_alu,
                                       input int max_ld, input int max_alu);
        return by_load ? (cnt + need_ld > max_ld) : (cnt + need_alu > max_alu);
    endfunction

endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard #(
    parameter int TAGW = 5,
    parameter int CW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [TAGW-1:0] wr_tag,
    input  logic [CW-1:0]   wr_cnt,
    input  logic            wr_ld,
    input  logic [TAGW-1:0] rd_a,
    input  logic [TAGW-1:0] rd_b,
    output logic [CW-1:0]   cnt_a,
    output logic [CW-1:0]   cnt_b,
    output logic            ld_a,
    output logic            ld_b
);
    localparam int NREG = 1 << TAGW;

    logic [CW-1:0] cnt_q [NREG];
    logic          ld_q  [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
                ld_q[g]  <= 1'b0;
            end else if (wr_en && wr_tag == TAGW'(g)) begin
                cnt_q[g] <= wr_cnt;
                ld_q[g]  <= wr_ld;
            end else if (cnt_q[g] != '0) begin
                cnt_q[g] <= cnt_q[g] - 1'b1;
            end
        end
    end

    assign cnt_a = cnt_q[rd_a];
    assign cnt_b = cnt_q[rd_b];
    assign ld_a  = ld_q[rd_a];
    assign ld_b  = ld_q[rd_b];
endmodule

// File: rtl/ilk_slot_fsm.sv
module ilk_slot_fsm
    import ilk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic is_branch,
    output logic in_slot
);
    slot_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SL_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SL_RUN:  if (issue && is_branch) state_d = SL_SLOT;
            SL_SLOT: if (issue)              state_d = SL_RUN;
            default: state_d = SL_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SL_SLOT: in_slot = 1'b1;
            default: in_slot = 1'b0;
        endcase
    end
endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock
    import ilk_pkg::*;
#(
    parameter int TAGW    = 5,
    parameter int CNT_W   = 16,
    parameter int LAT_FF  = 3,
    parameter int LAT_FS  = 2,
    parameter int LAT_LF  = 1,
    parameter int LAT_LS  = 0,
    parameter int LAT_II  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [2:0]       ins_op,
    input  logic [TAGW-1:0]  dst_i,
    input  logic [TAGW-1:0]  src_a_i,
    input  logic [TAGW-1:0]  src_b_i,
    output logic             stall_o,
    output logic             in_slot_o,
    output logic [CNT_W-1:0] stall_total_o
);
    localparam int M_FALU = imax(LAT_FF, LAT_FS);
    localparam int M_LDD  = imax(LAT_LF, LAT_LS);
    localparam int M_ALL  = imax(imax(M_FALU, M_LDD), LAT_II);
    localparam int CW     = (M_ALL < 1) ? 1 : $clog2(M_ALL + 1);

    op_e op;
    assign op = op_e'(ins_op);

    logic use_ia, use_ib, use_fa, use_fb, fb_store;
    logic [CW-1:0] ic_a, ic_b, fc_a, fc_b;
    logic il_a, il_b, fl_a, fl_b;
    logic hazard, issue;
    logic int_we, fp_we;
    logic [CW-1:0] fp_load_val;

    always_comb begin
        use_ia = 1'b0; use_ib = 1'b0; use_fa = 1'b0; use_fb = 1'b0; fb_store = 1'b0;
        unique case (op)
            OP_INT:  begin use_ia = 1'b1; use_ib = 1'b1; end
            OP_FALU: begin use_fa = 1'b1; use_fb = 1'b1; end
            OP_LDD:  use_ia = 1'b1;
            OP_STD:  begin use_ia = 1'b1; use_fb = 1'b1; fb_store = 1'b1; end
            OP_BR:   use_ia = 1'b1;
            default: ;
        endcase
    end

    ilk_scoreboard #(.TAGW(TAGW), .CW(CW)) u_int_sb (
        .clk(clk), .rst_n(rst_n),
        .wr_en(int_we), .wr_tag(dst_i), .wr_cnt(CW'(LAT_II)), .wr_ld(1'b0),
        .rd_a(src_a_i), .rd_b(src_b_i),
        .cnt_a(ic_a), .cnt_b(ic_b), .ld_a(il_a), .ld_b(il_b)
    );

    ilk_scoreboard #(.TAGW(TAGW), .CW(CW)) u_fp_sb (
        .clk(clk), .rst_n(rst_n),
        .wr_en(fp_we), .wr_tag(dst_i), .wr_cnt(fp_load_val), .wr_ld(op == OP_LDD),
        .rd_a(src_a_i), .rd_b(src_b_i),
        .cnt_a(fc_a), .cnt_b(fc_b), .ld_a(fl_a), .ld_b(fl_b)
    );

    always_comb begin
        hazard = 1'b0;
        if (use_ia && must_wait(int'(ic_a), il_a, LAT_II, LAT_II, LAT_II, LAT_II)) hazard = 1'b1;
        if (use_ib && must_wait(int'(ic_b), il_b, LAT_II, LAT_II, LAT_II, LAT_II)) hazard = 1'b1;
        if (use_fa && must_wait(int'(fc_a), fl_a, LAT_LF, LAT_FF, M_LDD, M_FALU)) hazard = 1'b1;
        if (use_fb) begin
            if (fb_store) begin
                if (must_wait(int'(fc_b), fl_b, LAT_LS, LAT_FS, M_LDD, M_FALU)) hazard = 1'b1;
            end else begin
                if (must_wait(int'(fc_b), fl_b, LAT_LF, LAT_FF, M_LDD, M_FALU)) hazard = 1'b1;
            end
        end
    end

    assign stall_o     = ins_valid && hazard;
    assign issue       = ins_valid && !hazard;
    assign int_we      = issue && (op == OP_INT);
    assign fp_we       = issue && (op == OP_FALU || op == OP_LDD);
    assign fp_load_val = (op == OP_LDD) ? CW'(M_LDD) : CW'(M_FALU);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stall_total_o <= '0;
        else if (stall_o) stall_total_o <= stall_total_o + 1'b1;
    end

    ilk_slot_fsm u_slot (
        .clk(clk), .rst_n(rst_n),
        .issue(issue), .is_branch(op == OP_BR),
        .in_slot(in_slot_o)
    );
endmodule

// File: rtl/ilk_checks.sv
module ilk_checks #(
    parameter int CNT_W  = 16,
    parameter int LAT_II = 0,
    parameter int MAXRUN = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_valid,
    input logic [2:0]       ins_op,
    input logic             stall_o,
    input logic             in_slot_o,
    input logic [CNT_W-1:0] stall_total_o
);
    logic [7:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= '0;
        else if (stall_o) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (int'(run_q) < MAXRUN)); // R2

    AST_INT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (LAT_II == 0 && ins_valid && ins_op == 3'd1) |-> !stall_o); // R6

    AST_SLOT_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !stall_o && ins_op == 3'd5 && !in_slot_o) |=> in_slot_o); // R9

    AST_SLOT_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !stall_o && in_slot_o) |=> !in_slot_o); // R9

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_o |=> $stable(stall_total_o)); // R10

    AST_CNT_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !$stable(stall_total_o)); // R10

    AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |-> !stall_o); // R11
endmodule

bind ilk_interlock ilk_checks #(.CNT_W(CNT_W), .LAT_II(LAT_II), .MAXRUN(M_ALL)) u_chk (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_op(ins_op),
    .stall_o(stall_o), .in_slot_o(in_slot_o), .stall_total_o(stall_total_o)
);

// File: tb/ilk_interlock_test.sv
`timescale 1ns/1ps
module ilk_interlock_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [2:0]  ins_op = 3'd0;
    logic [4:0]  dst_i = '0, src_a_i = '0, src_b_i = '0;
    logic        stall_o, in_slot_o;
    logic [15:0] stall_total_o;

    always #2.5 clk = ~clk;

    ilk_interlock uut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_op(ins_op),
        .dst_i(dst_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
        .stall_o(stall_o), .in_slot_o(in_slot_o), .stall_total_o(stall_total_o)
    );

    int vec = 0, bad = 0;
    int cyc = 0;
    int fp_at [32];
    int fp_kind [32];   // 0 none, 1 FP ALU, 2 load
    bit m_slot = 1'b0;
    int m_total = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int need(input int kind, input bit st);
        if (kind == 1) return st ? 2 : 3;
        if (kind == 2) return st ? 0 : 1;
        return 0;
    endfunction

    function automatic bit fp_wait(input int tag, input bit st);
        return (cyc - fp_at[tag]) <= need(fp_kind[tag], st);
    endfunction

    function automatic bit exp_stall(input int op, input int a, input int b);
        if (op == 2) return fp_wait(a, 1'b0) || fp_wait(b, 1'b0);
        if (op == 4) return fp_wait(b, 1'b1);
        return 1'b0;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ins_valid = 1'b0;
            #1;
            check(stall_o == 1'b0, "R11 idle no stall", stall_o, 0);
            @(posedge clk);
            cyc++;
        end
    endtask

    task automatic issue(input int op, input int d, input int a, input int b, output int ns);
        bit e;
        ns = 0;
        for (int guard = 0; guard < 16; guard++) begin
            @(negedge clk);
            ins_valid = 1'b1; ins_op = 3'(op);
            dst_i = 5'(d); src_a_i = 5'(a); src_b_i = 5'(b);
            #1;
            e = exp_stall(op, a, b);
            check(stall_o == e, "R7 per-cycle stall", stall_o, e);
            check(in_slot_o == m_slot, "R9 slot flag", in_slot_o, m_slot);
            @(posedge clk);
            if (e) begin
                ns++; m_total++; cyc++;
            end else begin
                if (op == 2) begin fp_kind[d] = 1; fp_at[d] = cyc; end
                if (op == 3) begin fp_kind[d] = 2; fp_at[d] = cyc; end
                m_slot = (op == 5) && !m_slot;
                cyc++;
                break;
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; vec++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin : main
        int ns, t0, sum;
        for (int i = 0; i < 32; i++) begin fp_at[i] = -100; fp_kind[i] = 0; end
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        check(stall_o == 1'b0, "R1 reset stall", stall_o, 0);
        check(in_slot_o == 1'b0, "R1 reset slot", in_slot_o, 0);
        check(stall_total_o == 16'd0, "R1 reset count", stall_total_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        idle(2);

        // R2
        issue(2, 1, 2, 3, ns); issue(2, 4, 1, 5, ns);
        check(ns == 3, "R2 FP ALU to FP ALU", ns, 3);
        idle(4);
        // R3
        issue(2, 1, 2, 3, ns); issue(4, 0, 1, 1, ns);
        check(ns == 2, "R3 FP ALU to store data", ns, 2);
        idle(4);
        // R4
        issue(3, 2, 1, 0, ns); issue(2, 3, 2, 2, ns);
        check(ns == 1, "R4 load to FP ALU", ns, 1);
        idle(4);
        // R5
        issue(3, 2, 1, 0, ns); issue(4, 0, 1, 2, ns);
        check(ns == 0, "R5 load to store data", ns, 0);
        idle(4);
        // R6
        issue(1, 1, 2, 3, ns); issue(1, 2, 1, 1, ns);
        check(ns == 0, "R6 int to int", ns, 0);
        issue(4, 0, 2, 9, ns);
        check(ns == 0, "R6 int to store base", ns, 0);
        issue(5, 0, 2, 0, ns);
        check(ns == 0, "R6 int to branch", ns, 0);
        issue(0, 0, 0, 0, ns);
        idle(4);
        // R7 spacing
        issue(2, 1, 2, 3, ns); issue(1, 7, 8, 9, ns); issue(2, 4, 1, 5, ns);
        check(ns == 2, "R7 one op between", ns, 2);
        idle(4);
        issue(2, 1, 2, 3, ns); issue(1, 7, 8, 9, ns); issue(1, 7, 8, 9, ns); issue(2, 4, 1, 5, ns);
        check(ns == 1, "R7 two ops between", ns, 1);
        idle(4);
        issue(2, 1, 2, 3, ns); issue(1, 7, 8, 9, ns); issue(1, 7, 8, 9, ns); issue(1, 7, 8, 9, ns);
        issue(2, 4, 1, 5, ns);
        check(ns == 0, "R7 three ops between", ns, 0);
        idle(4);
        // R8
        issue(2, 5, 2, 3, ns); issue(1, 6, 5, 5, ns);
        check(ns == 0, "R8 FP write vs int read", ns, 0);
        issue(1, 10, 1, 1, ns); issue(2, 11, 10, 10, ns);
        check(ns == 0, "R8 int write vs FP read", ns, 0);
        idle(4);
        // R11
        issue(2, 7, 2, 3, ns); issue(3, 7, 1, 0, ns);
        check(ns == 0, "R11 WAW no stall", ns, 0);
        issue(2, 8, 9, 12, ns); issue(2, 9, 13, 14, ns);
        check(ns == 0, "R11 WAR no stall", ns, 0);
        idle(4);
        // R9: slot flag across branch, slot, next
        issue(5, 0, 3, 0, ns);
        @(negedge clk); ins_valid = 1'b1; ins_op = 3'd1; #1;
        check(in_slot_o == 1'b1, "R9 slot after branch", in_slot_o, 1);
        @(posedge clk); cyc++; m_slot = 1'b0;
        @(negedge clk); #1;
        check(in_slot_o == 1'b0, "R9 slot cleared", in_slot_o, 0);
        @(posedge clk); cyc++;
        idle(4);
        // R12 unscheduled loop: 2 iterations
        t0 = stall_total_o; sum = 0;
        for (int it = 0; it < 2; it++) begin
            issue(3, 0, 1, 0, ns); sum += ns;
            issue(2, 4, 0, 2, ns); sum += ns;
            issue(4, 0, 1, 4, ns); sum += ns;
            issue(1, 1, 1, 0, ns); sum += ns;
            issue(5, 0, 1, 0, ns); sum += ns;
            issue(0, 0, 0, 0, ns); sum += ns;
        end
        check((12 + int'(stall_total_o) - t0) == 18, "R12 unscheduled 9/iter", 12 + int'(stall_total_o) - t0, 18);
        idle(4);
        t0 = stall_total_o;
        for (int it = 0; it < 2; it++) begin
            issue(3, 0, 1, 0, ns);
            issue(2, 4, 0, 2, ns);
            issue(1, 1, 1, 0, ns);
            issue(5, 0, 1, 0, ns);
            issue(4, 0, 1, 4, ns);
        end
        check((10 + int'(stall_total_o) - t0) == 12, "R12 scheduled 6/iter", 10 + int'(stall_total_o) - t0, 12);
        idle(4);

        // random mix on a small tag pool
        for (int n = 0; n < 600; n++) begin
            int op, d, a, b;
            op = int'($urandom_range(0, 5));
            d = int'($urandom_range(0, 3));
            a = int'($urandom_range(0, 3));
            b = int'($urandom_range(0, 3));
            if ($urandom_range(0, 9) == 0) idle(1);
            issue(op, d, a, b, ns);
        end
        @(negedge clk); ins_valid = 1'b0; #1;
        check(int'(stall_total_o) == m_total, "R10 stall total", stall_total_o, m_total);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule